// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block reads a run of bytes out of a one-time-programmable fuse macro. A single-cycle start pulse delivers a first address and a byte count. The sequencer then powers the macro up in stages, with a mandatory settle interval between the two power-enable stages. It performs one request/ready-poll access per address, then powers the macro down in the mirror order of power-up. Each byte fetched is presented for one cycle on a valid/data pair. A done pulse closes every request.

The macro side is a plain port. The sequencer drives an address together with a one-cycle request strobe, and the request clears the macro's ready flag. The sequencer waits for ready, which comes back after a variable number of cycles, and then takes the 8-bit data word. If ready never comes, a poll timer aborts the transfer with a busy error. The macro is still returned to its isolated, unpowered state before done is raised.

Top module: `fuse_read_seq`

## Requirements
- R1: Out of reset: macroMaskEn=0, macroPwrA=0, macroPwrB=0, macroIsolate=1, macroReq=0, byteValid=0, done=0, errBusy=0.
- R2: Power-up changes one macro control per cycle, in this order: macroMaskEn rises, macroPwrA rises, macroPwrB rises, macroIsolate falls. All of these happen before the first macroReq.
- R3: macroPwrB rises exactly SETTLE_CYC+1 cycles after macroPwrA rises. On power-down, macroPwrA falls exactly SETTLE_CYC+1 cycles after macroPwrB falls.
- R4: Each access raises macroReq for one cycle with macroAddr holding the address. A ready level seen before that request has no effect. byteData is the macroData value from the first cycle after the request in which macroReady is 1, and byteValid is high for exactly one cycle.
- R5: The addresses requested are startAddr, startAddr+1, … in increasing order, one per byte. Exactly byteCount bytes are delivered when no timeout occurs.
- R6: Power-down changes one control per cycle, in this order: macroIsolate rises, macroPwrB falls, macroPwrA falls, macroMaskEn falls.
- R7: If macroReady stays 0 for TIMEOUT_CYC poll cycles, the transfer stops. No further byte is delivered or requested, the full power-down of R6 still runs, and errBusy=1 at done.
- R8: done is a one-cycle pulse that rises one cycle after macroMaskEn falls. errBusy keeps its value from done until the next accepted start, and a clean transfer leaves it at 0.
- R9: A start with byteCount=0 raises done within three cycles. It makes no change to any macro control and leaves errBusy=0.
- R10: A startPulse that arrives while a transfer is in progress has no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | One-cycle request to begin a transfer |
| startAddr | input | ADDR_W | First fuse address |
| byteCount | input | CNT_W | Number of bytes to read |
| macroMaskEn | output | 1 | Write-mask enable to the macro power controller |
| macroPwrA | output | 1 | First power-enable stage |
| macroPwrB | output | 1 | Second power-enable stage |
| macroIsolate | output | 1 | Isolation between macro and core (1 = isolated) |
| macroReq | output | 1 | One-cycle access request, clears macro ready |
| macroAddr | output | ADDR_W | Address of the current access |
| macroReady | input | 1 | Macro reports data available |
| macroData | input | 8 | Macro read data |
| byteValid | output | 1 | One-cycle strobe for a fetched byte |
| byteData | output | 8 | Fetched byte |
| done | output | 1 | One-cycle end-of-request pulse |
| errBusy | output | 1 | Last request aborted on ready timeout |

## Verification
The assertions check on every cycle the local ordering rules of the power sequence. macroPwrB only rises with the mask and first stage on, isolation only opens with both stages on, and macroPwrB only drops while isolated. A monitor counter checks the settle window at each stage edge. Requests and bytes appear only while the macro is open, and done is a single cycle and only comes with the macro fully down. Only the bench scenarios show the full event order, the exact addresses and data of each byte, the zero-count and timeout paths, and that a stray start or a stale ready level changes nothing.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
  typedef struct packed {
    logic load;
    logic setMask;
    logic setPwrA;
    logic setPwrB;
    logic clrIso;
    logic setIso;
    logic clrPwrB;
    logic clrPwrA;
    logic clrMask;
    logic timerClr;
    logic timerInc;
    logic issue;
    logic capture;
    logic setErr;
    logic done;
  } seqStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PU_MASK, ST_PU_A, ST_PU_WAIT, ST_PU_B, ST_PU_ISO,
    ST_ISSUE, ST_ARM, ST_POLL,
    ST_PD_ISO, ST_PD_B, ST_PD_WAIT, ST_PD_A, ST_PD_MASK, ST_DONE
  } seqState_t;
endpackage

// File: rtl/fuse_seq_ctl.sv
module fuse_seq_ctl
  import fuse_seq_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             macroReady,
  input  logic             lastByte,
  input  logic             settleHit,
  input  logic             timeoutHit,
  output seqStrobe_t       stb
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (startPulse) begin
        stb.load = 1'b1;
        nextState = (byteCount == '0) ? ST_DONE : ST_PU_MASK;
      end
      ST_PU_MASK: begin stb.setMask = 1'b1; nextState = ST_PU_A; end
      ST_PU_A: begin stb.setPwrA = 1'b1; stb.timerClr = 1'b1; nextState = ST_PU_WAIT; end
      ST_PU_WAIT: begin
        stb.timerInc = 1'b1;
        if (settleHit) nextState = ST_PU_B;
      end
      ST_PU_B: begin stb.setPwrB = 1'b1; nextState = ST_PU_ISO; end
      ST_PU_ISO: begin stb.clrIso = 1'b1; nextState = ST_ISSUE; end
      ST_ISSUE: begin stb.issue = 1'b1; stb.timerClr = 1'b1; nextState = ST_ARM; end
      ST_ARM: nextState = ST_POLL;
      ST_POLL: begin
        if (macroReady) begin
          stb.capture = 1'b1;
          nextState = lastByte ? ST_PD_ISO : ST_ISSUE;
        end else if (timeoutHit) begin
          stb.setErr = 1'b1;
          nextState = ST_PD_ISO;
        end else begin
          stb.timerInc = 1'b1;
        end
      end
      ST_PD_ISO: begin stb.setIso = 1'b1; nextState = ST_PD_B; end
      ST_PD_B: begin stb.clrPwrB = 1'b1; stb.timerClr = 1'b1; nextState = ST_PD_WAIT; end
      ST_PD_WAIT: begin
        stb.timerInc = 1'b1;
        if (settleHit) nextState = ST_PD_A;
      end
      ST_PD_A: begin stb.clrPwrA = 1'b1; nextState = ST_PD_MASK; end
      ST_PD_MASK: begin stb.clrMask = 1'b1; nextState = ST_DONE; end
      ST_DONE: begin stb.done = 1'b1; nextState = ST_IDLE; end
      default: nextState = ST_IDLE;
    endcase
  end

  // R10: a start is only taken in idle
  assert_start_only_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> (state == ST_IDLE));
  // R4: a byte is only captured after the request/arm cycles
  assert_capture_after_arm_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> $past(state) inside {ST_ARM, ST_POLL});
endmodule

// File: rtl/fuse_seq_dp.sv
module fuse_seq_dp
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int CNT_W       = 11,
  parameter int SETTLE_CYC  = 250000,
  parameter int TIMEOUT_CYC = 250000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [7:0]        macroData,
  output logic              lastByte,
  output logic              settleHit,
  output logic              timeoutHit,
  output logic              macroMaskEn,
  output logic              macroPwrA,
  output logic              macroPwrB,
  output logic              macroIsolate,
  output logic              macroReq,
  output logic [ADDR_W-1:0] macroAddr,
  output logic              byteValid,
  output logic [7:0]        byteData,
  output logic              done,
  output logic              errBusy
);
  localparam int TMAX  = (TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC;
  localparam int TMR_W = $clog2(TMAX + 1);

  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remain;
  logic [TMR_W-1:0]  timer;

  assign lastByte   = (remain == CNT_W'(1));
  assign settleHit  = (timer == TMR_W'(SETTLE_CYC - 1));
  assign timeoutHit = (timer == TMR_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      remain  <= '0;
      timer   <= '0;
    end else begin
      if (stb.load) begin
        curAddr <= startAddr;
        remain  <= byteCount;
      end else if (stb.capture) begin
        curAddr <= curAddr + ADDR_W'(1);
        remain  <= remain - CNT_W'(1);
      end
      if (stb.timerClr)      timer <= '0;
      else if (stb.timerInc) timer <= timer + TMR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      macroMaskEn  <= 1'b0;
      macroPwrA    <= 1'b0;
      macroPwrB    <= 1'b0;
      macroIsolate <= 1'b1;
      macroReq     <= 1'b0;
      macroAddr    <= '0;
      byteValid    <= 1'b0;
      byteData     <= '0;
      done         <= 1'b0;
      errBusy      <= 1'b0;
    end else begin
      if (stb.setMask)      macroMaskEn  <= 1'b1;
      else if (stb.clrMask) macroMaskEn  <= 1'b0;
      if (stb.setPwrA)      macroPwrA    <= 1'b1;
      else if (stb.clrPwrA) macroPwrA    <= 1'b0;
      if (stb.setPwrB)      macroPwrB    <= 1'b1;
      else if (stb.clrPwrB) macroPwrB    <= 1'b0;
      if (stb.clrIso)       macroIsolate <= 1'b0;
      else if (stb.setIso)  macroIsolate <= 1'b1;
      macroReq  <= stb.issue;
      if (stb.issue) macroAddr <= curAddr;
      byteValid <= stb.capture;
      if (stb.capture) byteData <= macroData;
      done <= stb.done;
      if (stb.load)        errBusy <= 1'b0;
      else if (stb.setErr) errBusy <= 1'b1;
    end
  end

  // Monitor: cycles spent with stage A on and stage B off (saturating)
  localparam int SW = $clog2(SETTLE_CYC + 2);
  logic [SW-1:0] settleMon;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) settleMon <= '0;
    else if (!(macroPwrA && !macroPwrB)) settleMon <= '0;
    else if (settleMon != SW'(SETTLE_CYC)) settleMon <= settleMon + SW'(1);
  end

  assert_settle_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(macroPwrB) || $fell(macroPwrA)) |-> (settleMon == SW'(SETTLE_CYC)));
  assert_pwrb_needs_stage_a_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(macroPwrB) |-> (macroPwrA && macroMaskEn));
  assert_open_needs_power_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(macroIsolate) |-> macroPwrB);
  assert_pwrb_off_isolated_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(macroPwrB) |-> macroIsolate);
  assert_mask_off_unpowered_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(macroMaskEn) |-> (!macroPwrA && !macroPwrB));
  assert_req_only_open_R4: assert property (@(posedge clk) disable iff (!rstN)
    (macroReq || byteValid) |-> (!macroIsolate && macroPwrB));
  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_powered_down_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (macroIsolate && !macroPwrA && !macroPwrB && !macroMaskEn));
endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int CNT_W       = 11,
  parameter int SETTLE_CYC  = 250000,
  parameter int TIMEOUT_CYC = 250000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  output logic              macroMaskEn,
  output logic              macroPwrA,
  output logic              macroPwrB,
  output logic              macroIsolate,
  output logic              macroReq,
  output logic [ADDR_W-1:0] macroAddr,
  input  logic              macroReady,
  input  logic [7:0]        macroData,
  output logic              byteValid,
  output logic [7:0]        byteData,
  output logic              done,
  output logic              errBusy
);
  seqStrobe_t stb;
  logic lastByte, settleHit, timeoutHit;

  fuse_seq_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .byteCount(byteCount),
    .macroReady(macroReady), .lastByte(lastByte), .settleHit(settleHit),
    .timeoutHit(timeoutHit), .stb(stb));

  fuse_seq_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC),
                .TIMEOUT_CYC(TIMEOUT_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .startAddr(startAddr), .byteCount(byteCount),
    .macroData(macroData), .lastByte(lastByte), .settleHit(settleHit),
    .timeoutHit(timeoutHit), .macroMaskEn(macroMaskEn), .macroPwrA(macroPwrA),
    .macroPwrB(macroPwrB), .macroIsolate(macroIsolate), .macroReq(macroReq),
    .macroAddr(macroAddr), .byteValid(byteValid), .byteData(byteData),
    .done(done), .errBusy(errBusy));

  // R9: a zero-count start never touches the macro controls
  assert_zero_count_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && byteCount == '0) |=> (!macroMaskEn && macroIsolate));
endmodule

// File: tb/fuse_read_seq_bench.sv
module fuse_read_seq_bench;
  localparam int AW = 11, CW = 11, SETTLE = 6, TMO = 16;

  logic clk = 1'b0, rstN = 1'b0, startPulse = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [CW-1:0] byteCount = '0;
  logic macroMaskEn, macroPwrA, macroPwrB, macroIsolate, macroReq;
  logic [AW-1:0] macroAddr;
  logic macroReady = 1'b1;
  logic [7:0] macroData = 8'h00;
  logic byteValid, done, errBusy;
  logic [7:0] byteData;

  always #2 clk = ~clk;

  fuse_read_seq #(.ADDR_W(AW), .CNT_W(CW), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)) u_fuse_read_seq (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startAddr(startAddr),
    .byteCount(byteCount), .macroMaskEn(macroMaskEn), .macroPwrA(macroPwrA),
    .macroPwrB(macroPwrB), .macroIsolate(macroIsolate), .macroReq(macroReq),
    .macroAddr(macroAddr), .macroReady(macroReady), .macroData(macroData),
    .byteValid(byteValid), .byteData(byteData), .done(done), .errBusy(errBusy));

  int vecs = 0, errs = 0;
  int cyc = 0;

  function automatic logic [7:0] fuseVal(input logic [AW-1:0] a);
    return 8'((a * 7 + 3) ^ (a >> 8));
  endfunction

  // Macro model: request clears ready; ready returns after addr%4 cycles
  logic stuckEn = 1'b0;
  logic [AW-1:0] stuckAddr = '0;
  int latCnt = -1;
  logic [AW-1:0] holdAddr = '0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (macroReq) begin
      macroReady <= 1'b0;
      holdAddr   <= macroAddr;
      latCnt     <= (stuckEn && macroAddr == stuckAddr) ? 1000000 : int'(macroAddr % 4);
    end else if (!macroReady && latCnt >= 0) begin
      if (latCnt == 0) begin
        macroReady <= 1'b1;
        macroData  <= fuseVal(holdAddr);
        latCnt     <= -1;
      end else latCnt <= latCnt - 1;
    end
  end

  // Monitor: event order, stamps, requests and bytes
  int evLog[16]; int evN = 0; int multi = 0;
  int tArise = 0, tBrise = 0, tBfall = 0, tAfall = 0, tMfall = 0, tDone = 0, doneN = 0;
  logic [AW-1:0] reqLog[16]; int reqN = 0; int reqEarly = 0;
  logic [7:0] datLog[16]; int datN = 0;
  logic pM = 0, pA = 0, pB = 0, pI = 1;
  always @(negedge clk) if (rstN) begin
    int ch;
    ch = 0;
    if (macroMaskEn && !pM) begin if (evN < 16) evLog[evN] = 1; evN++; ch++; end
    if (macroPwrA && !pA) begin if (evN < 16) evLog[evN] = 2; evN++; ch++; tArise = cyc; end
    if (macroPwrB && !pB) begin if (evN < 16) evLog[evN] = 3; evN++; ch++; tBrise = cyc; end
    if (!macroIsolate && pI) begin if (evN < 16) evLog[evN] = 4; evN++; ch++; end
    if (macroIsolate && !pI) begin if (evN < 16) evLog[evN] = 5; evN++; ch++; end
    if (!macroPwrB && pB) begin if (evN < 16) evLog[evN] = 6; evN++; ch++; tBfall = cyc; end
    if (!macroPwrA && pA) begin if (evN < 16) evLog[evN] = 7; evN++; ch++; tAfall = cyc; end
    if (!macroMaskEn && pM) begin if (evN < 16) evLog[evN] = 8; evN++; ch++; tMfall = cyc; end
    if (ch > 1) multi++;
    pM = macroMaskEn; pA = macroPwrA; pB = macroPwrB; pI = macroIsolate;
    if (macroReq) begin
      if (macroIsolate) reqEarly++;
      if (reqN < 16) reqLog[reqN] = macroAddr;
      reqN++;
    end
    if (byteValid) begin if (datN < 16) datLog[datN] = byteData; datN++; end
    if (done) begin doneN++; tDone = cyc; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOne(input int sa, input int cnt, input bit stuck, input int stuckIdx,
                        input bit stray);
    int w;
    int expBytes;
    evN = 0; multi = 0; reqN = 0; datN = 0; doneN = 0; reqEarly = 0;
    stuckEn = stuck; stuckAddr = AW'(sa + stuckIdx);
    @(negedge clk);
    startAddr = AW'(sa); byteCount = CW'(cnt); startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    w = 0;
    while (doneN == 0 && w < 3000) begin
      @(negedge clk); w++;
      if (stray && datN == 1) begin
        startAddr = AW'(sa + 100); byteCount = CW'(1); startPulse = 1'b1;
      end else startPulse = 1'b0;
    end
    startPulse = 1'b0;
    check(doneN == 1, "R8 done seen", doneN, 1);
    @(negedge clk);
    check(doneN == 1, "R8 done single cycle", doneN, 1);
    expBytes = stuck ? stuckIdx : cnt;
    if (cnt == 0) begin
      check(evN == 0, "R9 no macro activity", evN, 0);
      check(reqN == 0, "R9 no request", reqN, 0);
      check(w <= 3, "R9 done latency", w, 3);
      check(errBusy == 1'b0, "R9 no error", errBusy, 0);
    end else begin
      check(evN == 8 && multi == 0, "R2 R6 event count", evN, 8);
      for (int k = 0; k < 8 && k < evN; k++)
        check(evLog[k] == k + 1, (k < 4) ? "R2 power-up order" : "R6 power-down order",
              evLog[k], k + 1);
      check(reqEarly == 0, "R2 request before open", reqEarly, 0);
      check(tBrise - tArise == SETTLE + 1, "R3 up settle", tBrise - tArise, SETTLE + 1);
      check(tAfall - tBfall == SETTLE + 1, "R3 down settle", tAfall - tBfall, SETTLE + 1);
      check(tDone - tMfall == 1, "R8 done after mask", tDone - tMfall, 1);
      check(datN == expBytes, stuck ? "R7 bytes before timeout" : "R5 byte count", datN, expBytes);
      check(reqN == (stuck ? stuckIdx + 1 : cnt), stuck ? "R7 requests" : "R5 requests",
            reqN, stuck ? stuckIdx + 1 : cnt);
      for (int k = 0; k < reqN && k < 16; k++)
        check(reqLog[k] == AW'(sa + k), stray ? "R10 request address" : "R5 request address",
              int'(reqLog[k]), int'(AW'(sa + k)));
      for (int k = 0; k < datN && k < 16; k++)
        check(datLog[k] == fuseVal(AW'(sa + k)), "R4 byte data", datLog[k],
              fuseVal(AW'(sa + k)));
      check(errBusy == stuck, stuck ? "R7 error flag" : "R8 clean error flag", errBusy, stuck);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(macroMaskEn == 0 && macroPwrA == 0 && macroPwrB == 0, "R1 power off", 0, 0);
    check(macroIsolate == 1 && macroReq == 0, "R1 isolated idle", macroIsolate, 1);
    check(byteValid == 0 && done == 0 && errBusy == 0, "R1 outputs low", done, 0);
    rstN = 1'b1;
    for (int s = 0; s < 3; s++)
      for (int n = 0; n <= 5; n++)
        runOne((s == 0) ? 0 : (s == 1) ? 'h0FE : 'h7F5, n, 1'b0, 0, 1'b0);
    runOne('h040, 5, 1'b1, 2, 1'b0);   // R7 timeout mid-run
    runOne('h041, 3, 1'b1, 0, 1'b0);   // R7 timeout on first byte
    runOne('h010, 4, 1'b0, 0, 1'b0);   // R8 error cleared by next start
    runOne('h200, 4, 1'b0, 0, 1'b1);   // R10 stray start ignored
    runOne('h300, 0, 1'b0, 0, 1'b0);   // R9 zero count again
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    vecs++; errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule